// File: doc/BRIEF.md
# Serial Peripheral Port with Completion and Collision Flags

This block is a byte-wide serial peripheral port for a small 8-bit controller bus. Software programs a control register (interrupt enable, port enable, master select, two-bit clock rate). Writing the data register starts an 8-bit exchange, and reading it returns the last byte received. As master, the block makes the serial clock by dividing the system clock. It drives the serial output, samples the serial input and watches the active-low select input. As slave, it shifts on an external serial clock while select is low.

A status register holds a completion flag and a write-collision flag. The two flags are cleared by a two-step software sequence: read status, then access data. The completion flag is also cleared by an interrupt acknowledge. An interrupt request is raised while the completion flag, the interrupt enable and a global interrupt enable are all high. A data write made while a byte is still shifting sets the collision flag and is otherwise dropped.

Top module: `spi_port`

## Requirements
- R1: After reset, all three registers read 0x00, `sck_o` is low and `irq` is low.
- R2: The bus address selects the register: 0 is control, 1 is status, 2 is data, 3 reads 0x00. Control bits are 7 interrupt enable, 6 port enable, 4 master select and 1:0 rate, and other control bits read 0. Status bit 7 is the completion flag, bit 6 is the collision flag, and bits 5:0 always read 0.
- R3: In master mode with the port enabled and idle, a data write starts an 8-bit exchange. `sdo_o` sends the byte MSB first and changes on falling `sck_o` edges. `sdi_i` is sampled on rising edges. `sck_o` is low whenever no master exchange is active.
- R4: The rate field sets the `sck_o` period to the system clock period times 4 (00), 16 (01), 64 (10) or 128 (11). The completion flag is visible exactly 8 × divisor clock edges after the edge that accepts the data write.
- R5: A data-register read returns the byte assembled from the serial input during the last completed exchange.
- R6: A data write while an exchange is active sets the collision flag. The written byte is dropped and the exchange in progress finishes unchanged.
- R7: `irq` is high exactly when the completion flag, control bit 7 and `glob_ie` are all high.
- R8: A pulse on `irq_ack` clears the completion flag and leaves the collision flag unchanged.
- R9: A status read that sees either flag set arms the clear sequence. The next data-register read or write then clears both flags. A data access made without that earlier status read clears nothing.
- R10: In master mode with the port enabled, `ss_n_i` low sets the completion flag.
- R11: In slave mode, while `ss_n_i` is low, the block samples `sdi_i` on rising `sck_i` edges and shifts `sdo_o` on falling edges. The completion flag sets after eight `sck_i` cycles, and the rate field has no effect.
- R12: With the port disabled, a data write starts no exchange and `sck_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drives the clear sequence) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| glob_ie | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge, clears the completion flag |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_i | input | 1 | Serial clock received in slave mode |
| ss_n_i | input | 1 | Active-low select input |
| sdo_o | output | 1 | Serial data out |
| sdi_i | input | 1 | Serial data in |

## Verification
The bench counts the cycles from the accepting write edge to the completion flag for every rate. A divider that is off by one half period, or that uses the wrong rate code, shows up as a wrong count. It injects a data write in the middle of a shift and then checks the outgoing bit stream and the collision flag; a design that reloads or restarts the shift register would send a corrupted byte. It makes a data access without an earlier status read and expects the flags to survive, which catches a clear that ignores the arming step. It also confirms that an acknowledge leaves the collision flag set. Select-low in master mode and a slow slave-mode exchange with the slowest rate code confirm that the flag sources and the rate gating are kept apart.

// File: rtl/spi_port_pkg.sv
`timescale 1ns/1ps
package spi_port_pkg;
    localparam int DATA_W   = 8;
    localparam int HALF_MAX = 64;
    localparam int CNT_W    = $clog2(HALF_MAX);

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_DATA = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    // system clocks per half period of the serial clock
    function automatic int unsigned half_period(input logic [1:0] rate);
        case (rate)
            2'b00:   return 2;
            2'b01:   return 8;
            2'b10:   return 32;
            default: return 64;
        endcase
    endfunction
endpackage

// File: rtl/spi_sckgen.sv
`timescale 1ns/1ps
module spi_sckgen
    import spi_port_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic [1:0] rate_i,
    output logic       sck_o,
    output logic       rise_o,
    output logic       fall_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          sck;
    } gen_t;

    gen_t          gen_q, gen_d;
    logic [CW-1:0] last_cnt;

    always_comb begin
        last_cnt = CW'(half_period(rate_i) - 1);
        gen_d    = gen_q;
        rise_o   = 1'b0;
        fall_o   = 1'b0;
        if (!run_i) begin
            gen_d.cnt = '0;
            gen_d.sck = 1'b0;
        end else if (gen_q.cnt == last_cnt) begin
            gen_d.cnt = '0;
            gen_d.sck = ~gen_q.sck;
            rise_o    = ~gen_q.sck;
            fall_o    = gen_q.sck;
        end else begin
            gen_d.cnt = gen_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gen_q <= '0;
        else        gen_q <= gen_d;
    end

    assign sck_o = gen_q.sck;
endmodule

// File: rtl/spi_shifter.sv
`timescale 1ns/1ps
module spi_shifter
    import spi_port_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         master_i,
    input  logic         load_i,
    input  logic [W-1:0] wdata_i,
    input  logic         rise_i,
    input  logic         fall_i,
    input  logic         sdi_i,
    output logic         sdo_o,
    output logic         active_o,
    output logic         done_o,
    output logic [W-1:0] rxbuf_o
);
    localparam int BW = $clog2(W);

    typedef struct packed {
        logic [W-1:0]  sh;
        logic [W-1:0]  rx;
        logic [BW-1:0] cnt;
        logic          samp;
        logic          active;
    } shf_t;

    shf_t shf_q, shf_d;

    always_comb begin
        shf_d  = shf_q;
        done_o = 1'b0;
        if (!en_i) begin
            shf_d.active = 1'b0;
            shf_d.cnt    = '0;
        end else begin
            if (load_i) begin
                shf_d.sh     = wdata_i;
                shf_d.cnt    = '0;
                shf_d.active = master_i;
            end
            if (rise_i && (shf_q.active || !master_i)) begin
                shf_d.samp   = sdi_i;
                shf_d.active = 1'b1;
            end
            if (fall_i && shf_q.active) begin
                shf_d.sh = {shf_q.sh[W-2:0], shf_q.samp};
                if (shf_q.cnt == BW'(W - 1)) begin
                    done_o       = 1'b1;
                    shf_d.active = 1'b0;
                    shf_d.cnt    = '0;
                    shf_d.rx     = {shf_q.sh[W-2:0], shf_q.samp};
                end else begin
                    shf_d.cnt = shf_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shf_q <= '0;
        else        shf_q <= shf_d;
    end

    assign sdo_o    = shf_q.sh[W-1];
    assign active_o = shf_q.active;
    assign rxbuf_o  = shf_q.rx;
endmodule

// File: rtl/spi_flags.sv
`timescale 1ns/1ps
module spi_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic set_done_i,
    input  logic set_wcol_i,
    input  logic stat_rd_i,
    input  logic data_acc_i,
    input  logic ack_i,
    output logic spif_o,
    output logic wcol_o
);
    typedef struct packed {
        logic spif;
        logic wcol;
        logic armed;
    } flg_t;

    flg_t flg_q, flg_d;

    always_comb begin
        flg_d = flg_q;
        if (stat_rd_i && (flg_q.spif || flg_q.wcol)) flg_d.armed = 1'b1;
        if (data_acc_i && flg_q.armed) begin
            flg_d.spif  = 1'b0;
            flg_d.wcol  = 1'b0;
            flg_d.armed = 1'b0;
        end
        if (ack_i)      flg_d.spif = 1'b0;
        if (set_done_i) flg_d.spif = 1'b1;
        if (set_wcol_i) flg_d.wcol = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    assign spif_o = flg_q.spif;
    assign wcol_o = flg_q.wcol;
endmodule

// File: rtl/spi_port.sv
`timescale 1ns/1ps
module spi_port
    import spi_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       glob_ie,
    output logic       irq,
    input  logic       irq_ack,
    output logic       sck_o,
    input  logic       sck_i,
    input  logic       ss_n_i,
    output logic       sdo_o,
    input  logic       sdi_i
);
    typedef struct packed {
        logic       ie;
        logic       en;
        logic       mstr;
        logic [1:0] rate;
        logic [1:0] sck_s;
        logic       sck_p;
        logic [1:0] ss_s;
    } top_t;

    top_t       st_q, st_d;
    reg_sel_e   sel;
    logic       data_wr, data_acc, stat_rd;
    logic       xfer_active, xfer_done, load, collide;
    logic       gen_rise, gen_fall, slv_rise, slv_fall, ss_low;
    logic       tick_rise, tick_fall, set_done, run_gen;
    logic       spif, wcol;
    logic [7:0] rxbuf;

    always_comb begin
        sel      = reg_sel_e'(bus_addr);
        data_wr  = bus_wr && (sel == REG_DATA);
        data_acc = (bus_wr || bus_rd) && (sel == REG_DATA);
        stat_rd  = bus_rd && (sel == REG_STAT);
        load     = data_wr && st_q.en && !xfer_active;
        collide  = data_wr && xfer_active;
        ss_low   = !st_q.ss_s[1];
        slv_rise = st_q.sck_s[1] && !st_q.sck_p;
        slv_fall = !st_q.sck_s[1] && st_q.sck_p;
        run_gen  = st_q.en && st_q.mstr && xfer_active;
        tick_rise = st_q.mstr ? gen_rise : (slv_rise && ss_low);
        tick_fall = st_q.mstr ? gen_fall : (slv_fall && ss_low);
        set_done = xfer_done || (st_q.en && st_q.mstr && ss_low);

        st_d       = st_q;
        st_d.sck_s = {st_q.sck_s[0], sck_i};
        st_d.sck_p = st_q.sck_s[1];
        st_d.ss_s  = {st_q.ss_s[0], ss_n_i};
        if (bus_wr && (sel == REG_CTRL)) begin
            st_d.ie   = bus_wdata[7];
            st_d.en   = bus_wdata[6];
            st_d.mstr = bus_wdata[4];
            st_d.rate = bus_wdata[1:0];
        end

        case (sel)
            REG_CTRL: bus_rdata = {st_q.ie, st_q.en, 1'b0, st_q.mstr, 2'b00, st_q.rate};
            REG_STAT: bus_rdata = {spif, wcol, 6'b0};
            REG_DATA: bus_rdata = rxbuf;
            default:  bus_rdata = 8'h00;
        endcase
        irq = spif && st_q.ie && glob_ie;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.ss_s <= 2'b11;
        end else begin
            st_q <= st_d;
        end
    end

    spi_sckgen #(.CW(CNT_W)) u_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run_gen),
        .rate_i (st_q.rate),
        .sck_o  (sck_o),
        .rise_o (gen_rise),
        .fall_o (gen_fall)
    );

    spi_shifter #(.W(DATA_W)) u_shf (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (st_q.en),
        .master_i (st_q.mstr),
        .load_i   (load),
        .wdata_i  (bus_wdata),
        .rise_i   (tick_rise),
        .fall_i   (tick_fall),
        .sdi_i    (sdi_i),
        .sdo_o    (sdo_o),
        .active_o (xfer_active),
        .done_o   (xfer_done),
        .rxbuf_o  (rxbuf)
    );

    spi_flags u_flg (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_done_i (set_done),
        .set_wcol_i (collide),
        .stat_rd_i  (stat_rd),
        .data_acc_i (data_acc),
        .ack_i      (irq_ack),
        .spif_o     (spif),
        .wcol_o     (wcol)
    );
endmodule

// File: rtl/spi_port_chk.sv
`timescale 1ns/1ps
module spi_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] bus_addr,
    input logic       bus_wr,
    input logic [7:0] bus_rdata,
    input logic       glob_ie,
    input logic       irq,
    input logic       irq_ack,
    input logic       sck_o,
    input logic       xfer_active,
    input logic       port_en,
    input logic       set_done,
    input logic       spif,
    input logic       wcol
);
    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd1) |-> (bus_rdata[5:0] == 6'd0)); // R2
    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_active |-> !sck_o); // R3
    AST_WCOL_ON_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd2 && xfer_active) |=> wcol); // R6
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (glob_ie && spif)); // R7
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !set_done) |=> !spif); // R8
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> !sck_o); // R12
endmodule

bind spi_port spi_port_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_rdata   (bus_rdata),
    .glob_ie     (glob_ie),
    .irq         (irq),
    .irq_ack     (irq_ack),
    .sck_o       (sck_o),
    .xfer_active (xfer_active),
    .port_en     (st_q.en),
    .set_done    (set_done),
    .spif        (spif),
    .wcol        (wcol)
);

// File: tb/spi_port_tb_top.sv
`timescale 1ns/1ps
module spi_port_tb_top;
    localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2, A_NONE = 2'd3;
    localparam logic [7:0] C_IE = 8'h80, C_EN = 8'h40, C_MS = 8'h10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       glob_ie = 1'b0, irq, irq_ack = 1'b0;
    logic       sck_o, sck_i = 1'b0, ss_n_i = 1'b1, sdo_o, sdi_i = 1'b0;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    spi_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .glob_ie(glob_ie), .irq(irq), .irq_ack(irq_ack), .sck_o(sck_o),
        .sck_i(sck_i), .ss_n_i(ss_n_i), .sdo_o(sdo_o), .sdi_i(sdi_i)
    );

    function automatic int divisor(input logic [1:0] r);
        return (r == 2'b11) ? 128 : (4 << (2 * r));
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // master exchange with a bench slave model; optional colliding write
    task automatic run_master(input logic [7:0] tx, input logic [7:0] slv,
                              input int col_at, input logic [7:0] col,
                              output int cycles, output logic [7:0] seen);
        int  si;
        logic prev;
        logic [7:0] st;
        si = 6; prev = 1'b0; seen = 8'h00; cycles = 0;
        sdi_i = slv[7];
        bus_write(A_DATA, tx);
        bus_addr = A_STAT;
        for (int n = 1; n < 3000; n++) begin
            @(negedge clk);
            cycles = n;
            if (sck_o && !prev) seen = {seen[6:0], sdo_o};
            if (!sck_o && prev && si >= 0) begin sdi_i = slv[si]; si--; end
            prev = sck_o;
            peek(A_STAT, st);
            if (st[7]) break;
            if (col_at == n) begin
                bus_addr = A_DATA; bus_wdata = col; bus_wr = 1'b1;
                @(negedge clk);
                n++; cycles = n;
                bus_wr = 1'b0; bus_addr = A_STAT;
                if (sck_o && !prev) seen = {seen[6:0], sdo_o};
                prev = sck_o;
            end
        end
    endtask

    initial begin
        #1_000_000;
        fails++; tests++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] d, tx, slv, seen;
        logic [1:0] r;
        int cyc;
        logic hi;
        void'($urandom(32'h5EED_0417));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        peek(A_CTRL, d); check("R1 ctrl", d, 8'h00);
        peek(A_STAT, d); check("R1 stat", d, 8'h00);
        peek(A_DATA, d); check("R1 data", d, 8'h00);
        check("R1 sck", sck_o, 0);
        check("R1 irq", irq, 0);

        // R2 register map
        bus_write(A_CTRL, 8'hFF);
        peek(A_CTRL, d); check("R2 ctrl readback", d, 8'hD3);
        peek(A_NONE, d); check("R2 unused addr", d, 8'h00);

        // R12 disabled port ignores data write
        bus_write(A_CTRL, C_MS | 8'h01);
        bus_write(A_DATA, 8'hA5);
        hi = 1'b0;
        repeat (80) begin @(negedge clk); if (sck_o) hi = 1'b1; end
        check("R12 sck idle", hi, 0);
        peek(A_STAT, d); check("R12 no flag", d, 8'h00);

        // R3 R4 R5 R7 R9 random master exchanges
        for (int k = 0; k < 8; k++) begin
            r   = (k < 4) ? 2'(k) : 2'($urandom_range(0, 3));
            tx  = 8'($urandom);
            slv = 8'($urandom);
            glob_ie = 1'($urandom);
            bus_write(A_CTRL, C_IE | C_EN | C_MS | {6'b0, r});
            run_master(tx, slv, 0, 8'h00, cyc, seen);
            check("R4 exchange length", cyc, 8 * divisor(r));
            check("R3 mosi stream", seen, tx);
            check("R3 sck idle after", sck_o, 0);
            check("R7 irq", irq, glob_ie);
            bus_read(A_DATA, d);
            check("R5 data without arm", d, slv);
            peek(A_STAT, d); check("R9 flag kept without arm", d, 8'h80);
            bus_read(A_STAT, d);
            bus_read(A_DATA, d);
            check("R5 rx byte", d, slv);
            peek(A_STAT, d); check("R9 cleared", d, 8'h00);
        end

        // R6 collision, R8 ack
        glob_ie = 1'b1;
        bus_write(A_CTRL, C_IE | C_EN | C_MS | 8'h01);
        run_master(8'h3C, 8'h96, 20, 8'hFF, cyc, seen);
        check("R6 stream unchanged", seen, 8'h3C);
        check("R6 length unchanged", cyc, 128);
        peek(A_STAT, d); check("R6 flags", d, 8'hC0);
        check("R7 irq up", irq, 1);
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        peek(A_STAT, d); check("R8 ack keeps wcol", d, 8'h40);
        check("R8 irq down", irq, 0);
        bus_read(A_STAT, d);
        bus_read(A_DATA, d);
        check("R6 rx from kept exchange", d, 8'h96);
        peek(A_STAT, d); check("R9 wcol cleared", d, 8'h00);

        // R10 select low in master mode
        ss_n_i = 1'b0;
        repeat (5) @(negedge clk);
        peek(A_STAT, d); check("R10 ss flag", d[7], 1);
        ss_n_i = 1'b1;
        repeat (4) @(negedge clk);
        bus_read(A_STAT, d);
        bus_read(A_DATA, d);
        peek(A_STAT, d); check("R10 cleared", d, 8'h00);

        // R11 slave mode, slowest rate code set
        bus_write(A_CTRL, C_EN | 8'h03);
        tx = 8'hB4; slv = 8'h5A; seen = 8'h00;
        bus_write(A_DATA, tx);
        ss_n_i = 1'b0; sdi_i = slv[7];
        for (int i = 0; i < 8; i++) begin
            repeat (8) @(negedge clk);
            seen = {seen[6:0], sdo_o};
            sck_i = 1'b1;
            repeat (8) @(negedge clk);
            sck_i = 1'b0;
            if (i < 7) sdi_i = slv[6 - i];
        end
        repeat (6) @(negedge clk);
        peek(A_STAT, d); check("R11 slave done", d, 8'h80);
        check("R11 sck_o quiet", sck_o, 0);
        ss_n_i = 1'b1;
        check("R11 slave out stream", seen, tx);
        bus_read(A_STAT, d);
        bus_read(A_DATA, d);
        check("R11 slave rx", d, slv);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule